// File: doc/BRIEF.md
# Monitor Message Transmitter

This block sends a short message, one byte per frame, over the monitor slot of a frame-based serial control channel. A local buffer holds up to `DEPTH` bytes, and a start request supplies the message length. The block drives the byte, an output enable for the slot and an active-low end/valid line `e_n`. It samples an active-low acknowledge line `a_n` that comes back from the remote receiver. Bit-level serialization, pad drive and the receiving side of the handshake belong to other blocks.

All handshake activity is paced by a one-cycle frame strobe, and every protocol output is updated only on that strobe. The block waits until the receiver is idle, then presents each byte for at least two frames. It moves to the next byte only after the receiver pre-acknowledges the current one. When the receiver aborts, the block resends the whole message from the first byte. It gives up when eight counted frames pass without a successful acknowledgement.

Top module: `mon_msg_tx`

## Requirements
- R1: After reset, `e_n` is 1, `mon_oe` is 0, and `done`, `retry` and `aborted` are 0.
- R2: A start request is ignored when `msg_len` is 0 or greater than `DEPTH` (default 8). It is also ignored while a message is in progress, and the running message then keeps its own length and frame count.
- R3: After an accepted start, the first byte goes out only at a strobe where `a_n` is sampled as 1. At that strobe `e_n` goes to 0, `mon_oe` goes to 1 and `mon_byte` shows buffer entry 0. While `a_n` is sampled as 0, `e_n` stays 1 and `mon_oe` stays 0.
- R4: `mon_byte`, `mon_oe` and `e_n` change only at clock edges where `frame_stb` is 1.
- R5: Each byte stays on `mon_byte` for at least two strobes. A pre-acknowledge level that is sampled at the first strobe after a byte was freshly presented is ignored.
- R6: A pre-acknowledge is an `a_n` sample that differs from the resting level: 1 for byte 0, 0 for every later byte. If more bytes remain, the next byte is presented at that strobe with `e_n` = 1. At the following strobe, `a_n` = 0 (acknowledge) returns `e_n` to 0 and the byte is held.
- R7: At the pre-acknowledge of the last byte, `e_n` stays 1 and `mon_oe` goes to 0. An acknowledge at the next strobe raises `done` for exactly one clock cycle, and `e_n` stays 1.
- R8: If `a_n` is 1 at the strobe after a pre-acknowledge, that is an abort. `retry` pulses for one cycle, and at the same strobe byte 0 is presented again with `e_n` = 0 and `mon_oe` = 1.
- R9: Strobes are counted during a transfer from the start, or from the last acknowledge. Strobes that do not carry an acknowledge increment the count, retries included. The 8th such strobe sets the sticky `aborted` flag, returns `e_n` to 1 and `mon_oe` to 0, and ends the transfer. The next accepted start clears `aborted`.
- R10: Whenever `mon_oe` is 0, `e_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_stb | input | 1 | One-cycle frame boundary strobe |
| wr_en | input | 1 | Buffer write enable |
| wr_addr | input | $clog2(DEPTH) | Buffer write index |
| wr_data | input | 8 | Buffer write byte |
| start | input | 1 | Message start request |
| msg_len | input | $clog2(DEPTH+1) | Number of bytes to send |
| a_n | input | 1 | Acknowledge from the receiver, active low |
| mon_byte | output | 8 | Byte presented in the monitor slot |
| mon_oe | output | 1 | Slot output enable (0 means tri-stated) |
| e_n | output | 1 | End/valid bit, active low |
| done | output | 1 | One-cycle pulse when the message is acknowledged |
| aborted | output | 1 | Sticky flag set when the frame limit is reached |
| retry | output | 1 | One-cycle pulse when a full resend begins |

## Verification
Every protocol result (`mon_byte`, `mon_oe`, `e_n`, `done`, `retry`, `aborted` being set) is registered at the very strobe edge that samples `a_n`. The bench therefore checks it at the falling edge right after that strobe, before any further rising edge, which is the only moment a one-cycle `done` or `retry` pulse can be seen. Clearing `aborted` on a start takes one clock and is checked at the falling edge after the start cycle. The three slot outputs are also compared just before each strobe against the values taken right after the previous strobe, which shows that nothing moved in between.

// File: rtl/mtx_pkg.sv
// Shared types for the monitor message transmitter.
package mtx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE, // no transfer; slot released
        ST_ARM,  // start accepted, waiting for the receiver to be idle
        ST_SEND, // a byte is held, waiting for a pre-acknowledge
        ST_ACK   // pre-acknowledge seen, expecting the acknowledge
    } mtx_state_e;
endpackage

// File: rtl/mtx_msg_buf.sv
// Message byte store: one write port and one combinational read port.
// Assumes DEPTH is a power of two, so every read index is in range.
module mtx_msg_buf #(
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Each entry loads the write byte when its index is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && (wr_addr == AW'(g)))
                mem[g] <= wr_data;
        end
    end

    // Read port used by the controller to fetch the byte to present.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mtx_frame_limit.sv
// Counts handshake strobes that carry no acknowledge, and flags the strobe
// that would reach LIMIT. Assumes the controller clears it on start and on
// every acknowledge, and stops ticking after the flag.
module mtx_frame_limit #(
    parameter int LIMIT = 8,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    output logic hit
);
    logic [CW-1:0] cnt;

    // Counter of strobes without an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // The LIMIT-th counted strobe is the one that gives up.
    assign hit = tick && (cnt == CW'(LIMIT - 1));

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT));
    p_hit_then_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !tick);
endmodule

// File: rtl/mtx_ctrl.sv
// Handshake controller for the transmit side of the monitor channel.
// Samples a_n and updates every slot output only on frame_stb. Assumes
// frame_stb is a single-cycle pulse and that rd_data follows rd_addr
// within the same cycle.
module mtx_ctrl
    import mtx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic          start,
    input  logic [LW-1:0] msg_len,
    input  logic          a_n,
    input  logic [7:0]    rd_data,
    input  logic          limit_hit,
    output logic [AW-1:0] rd_addr,
    output logic          cnt_tick,
    output logic          cnt_clr,
    output logic [7:0]    mon_byte,
    output logic          mon_oe,
    output logic          e_n,
    output logic          done,
    output logic          aborted,
    output logic          retry
);
    mtx_state_e    state;
    logic [AW-1:0] idx;
    logic [LW-1:0] len;
    logic          held;
    logic          last_r;

    logic          len_ok, accept, a_rest, preack, ack_ok, more;

    // Decode the start request, the handshake events and the read index.
    always_comb begin
        len_ok   = (msg_len != '0) && (msg_len <= LW'(DEPTH));
        accept   = (state == ST_IDLE) && start && len_ok;
        a_rest   = (idx == '0);
        preack   = (state == ST_SEND) && held && (a_n != a_rest);
        ack_ok   = (state == ST_ACK) && !a_n;
        more     = (LW'(idx) + 1'b1) < len;
        cnt_tick = frame_stb && ((state == ST_SEND) || ((state == ST_ACK) && a_n));
        cnt_clr  = accept || (frame_stb && ack_ok);
        rd_addr  = (state == ST_SEND) ? idx + 1'b1 : '0;
    end

    // Protocol state machine; slot outputs move only on the frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            len      <= '0;
            held     <= 1'b0;
            last_r   <= 1'b0;
            mon_byte <= '0;
            mon_oe   <= 1'b0;
            e_n      <= 1'b1;
            done     <= 1'b0;
            aborted  <= 1'b0;
            retry    <= 1'b0;
        end else begin
            done  <= 1'b0;
            retry <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        len     <= msg_len;
                        aborted <= 1'b0;
                        state   <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (frame_stb && a_n) begin
                        idx      <= '0;
                        mon_byte <= rd_data;
                        mon_oe   <= 1'b1;
                        e_n      <= 1'b0;
                        held     <= 1'b0;
                        last_r   <= 1'b0;
                        state    <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (frame_stb) begin
                        if (limit_hit) begin
                            e_n     <= 1'b1;
                            mon_oe  <= 1'b0;
                            aborted <= 1'b1;
                            state   <= ST_IDLE;
                        end else if (preack) begin
                            e_n   <= 1'b1;
                            state <= ST_ACK;
                            if (more) begin
                                idx      <= idx + 1'b1;
                                mon_byte <= rd_data;
                                last_r   <= 1'b0;
                            end else begin
                                mon_oe <= 1'b0;
                                last_r <= 1'b1;
                            end
                        end else begin
                            held <= 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (frame_stb) begin
                        if (ack_ok) begin
                            if (last_r) begin
                                done  <= 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                e_n   <= 1'b0;
                                held  <= 1'b1;
                                state <= ST_SEND;
                            end
                        end else if (limit_hit) begin
                            e_n     <= 1'b1;
                            mon_oe  <= 1'b0;
                            aborted <= 1'b1;
                            state   <= ST_IDLE;
                        end else begin
                            retry    <= 1'b1;
                            idx      <= '0;
                            mon_byte <= rd_data;
                            mon_oe   <= 1'b1;
                            e_n      <= 1'b0;
                            held     <= 1'b0;
                            last_r   <= 1'b0;
                            state    <= ST_SEND;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_off_means_e_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_oe |-> e_n);
    p_strobe_paced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(e_n) && $stable(mon_oe) && $stable(mon_byte)));
    p_wait_idle_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && frame_stb && !a_n) |=> (state == ST_ARM && e_n));
    p_done_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (e_n && !mon_oe && state == ST_IDLE));
    p_retry_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> (!e_n && mon_oe && state == ST_SEND && idx == '0));
    p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aborted) |-> (e_n && !mon_oe && state == ST_IDLE));
endmodule

// File: rtl/mon_msg_tx.sv
// Top of the monitor message transmitter: byte store, handshake controller
// and frame limit counter. Assumes frame_stb lasts one clock per frame and
// that the buffer is not rewritten during a transfer.
module mon_msg_tx #(
    parameter int DEPTH    = 8,
    parameter int MAX_WAIT = 8,
    localparam int AW      = $clog2(DEPTH),
    localparam int LW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          start,
    input  logic [LW-1:0] msg_len,
    input  logic          a_n,
    output logic [7:0]    mon_byte,
    output logic          mon_oe,
    output logic          e_n,
    output logic          done,
    output logic          aborted,
    output logic          retry
);
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          cnt_tick, cnt_clr, limit_hit;

    mtx_msg_buf #(.DEPTH(DEPTH), .AW(AW)) buf_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    mtx_frame_limit #(.LIMIT(MAX_WAIT)) lim_i (
        .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .clr(cnt_clr), .hit(limit_hit)
    );

    mtx_ctrl #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .start(start),
        .msg_len(msg_len), .a_n(a_n), .rd_data(rd_data), .limit_hit(limit_hit),
        .rd_addr(rd_addr), .cnt_tick(cnt_tick), .cnt_clr(cnt_clr),
        .mon_byte(mon_byte), .mon_oe(mon_oe), .e_n(e_n), .done(done),
        .aborted(aborted), .retry(retry)
    );
endmodule

// File: tb/mon_msg_tx_tb_top.sv
module mon_msg_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME_CYC  = 4;
    localparam int DEPTH      = 8;
    localparam int WDOG       = 100000;
    // Scenario table: {length, abort byte index (15 = none)}.
    localparam logic [7:0] SCEN [6] = '{8'h1F, 8'h3F, 8'h41, 8'h20, 8'h87, 8'h54};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       start = 1'b0;
    logic [3:0] msg_len = '0;
    logic       a_n = 1'b1;
    logic [7:0] mon_byte;
    logic       mon_oe, e_n, done, aborted, retry;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] ebuf [DEPTH];

    always #(CLK_PERIOD / 2) clk = ~clk;

    mon_msg_tx #(.DEPTH(DEPTH), .MAX_WAIT(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .start(start), .msg_len(msg_len),
        .a_n(a_n), .mon_byte(mon_byte), .mon_oe(mon_oe), .e_n(e_n),
        .done(done), .aborted(aborted), .retry(retry)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // One frame: hold the slot outputs through the gap, then strobe with a.
    task automatic frame(input logic a);
        logic [9:0] snap;
        snap = {mon_byte, mon_oe, e_n};
        repeat (FRAME_CYC - 1) @(negedge clk);
        chk("R4 slot stable between strobes", {22'd0, mon_byte, mon_oe, e_n}, {22'd0, snap});
        a_n = a;
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic start_msg(input int len);
        @(negedge clk);
        start = 1'b1;
        msg_len = 4'(len);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic load(input int s);
        for (int i = 0; i < DEPTH; i++) begin
            ebuf[i] = 8'(8'h3C + s * 17 + i * 53);
            @(negedge clk);
            wr_en = 1'b1;
            wr_addr = 3'(i);
            wr_data = ebuf[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Full message with a well-behaved receiver; optional single abort.
    task automatic run_msg(input int len, input int ab);
        int  i;
        logic rest;
        logic aborted_once;
        aborted_once = 1'b0;
        start_msg(len);
        frame(1'b1);
        chk("R3 first byte e_n", {31'd0, e_n}, 32'd0);
        chk("R3 first byte value", {24'd0, mon_byte}, {24'd0, ebuf[0]});
        i = 0;
        while (i < len) begin
            rest = (i == 0);
            frame(rest);
            chk("R5 byte held", {23'd0, mon_byte, e_n}, {23'd0, ebuf[i], 1'b0});
            frame(!rest);
            if (i < len - 1)
                chk("R6 next byte with e_n high", {22'd0, mon_byte, mon_oe, e_n},
                    {22'd0, ebuf[i+1], 2'b11});
            else begin
                chk("R7 end marker", {30'd0, mon_oe, e_n}, 32'd1);
                chk("R10 released slot keeps e_n high", {31'd0, e_n}, 32'd1);
            end
            if (i == ab && !aborted_once) begin
                frame(1'b1);
                chk("R8 retry restart", {21'd0, retry, mon_byte, mon_oe, e_n},
                    {21'd0, 1'b1, ebuf[0], 2'b10});
                aborted_once = 1'b1;
                i = 0;
            end else begin
                frame(1'b0);
                if (i < len - 1)
                    chk("R6 ack re-asserts e_n", {22'd0, done, mon_byte, e_n},
                        {22'd0, 1'b0, ebuf[i+1], 1'b0});
                else
                    chk("R7 done pulse", {30'd0, done, e_n}, 32'd3);
                i++;
            end
        end
        @(negedge clk);
        chk("R7 done one cycle", {30'd0, done, e_n}, 32'd1);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all act=timeout exp=finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", {27'd0, e_n, mon_oe, done, aborted, retry}, 32'h10);

        // Table of message scenarios.
        for (int s = 0; s < 6; s++) begin
            load(s);
            run_msg(int'(SCEN[s][7:4]), int'(SCEN[s][3:0]));
        end

        // R2: bad lengths are ignored.
        load(7);
        start_msg(0);
        frame(1'b1);
        chk("R2 zero length ignored", {30'd0, mon_oe, e_n}, 32'd1);
        start_msg(9);
        frame(1'b1);
        chk("R2 oversize length ignored", {30'd0, mon_oe, e_n}, 32'd1);

        // R3: wait for an idle receiver, then R9 timeout with R2 busy start.
        a_n = 1'b0;
        start_msg(3);
        frame(1'b0);
        chk("R3 held off while a_n low", {30'd0, mon_oe, e_n}, 32'd1);
        frame(1'b0);
        chk("R3 still held off", {30'd0, mon_oe, e_n}, 32'd1);
        frame(1'b1);
        chk("R3 starts after idle frame", {22'd0, mon_byte, mon_oe, e_n}, {22'd0, ebuf[0], 2'b10});
        for (int k = 1; k <= 7; k++) begin
            frame(1'b1);
            if (k == 3) start_msg(2);
        end
        chk("R9 not yet aborted at 7", {29'd0, aborted, mon_oe, e_n}, 32'd2);
        frame(1'b1);
        chk("R9 gives up at 8 (R2 busy start ignored)", {29'd0, aborted, mon_oe, e_n}, 32'd5);

        // R9: next start clears the sticky flag; short message completes.
        start_msg(1);
        chk("R9 aborted cleared by start", {31'd0, aborted}, 32'd0);
        frame(1'b1);
        frame(1'b1);
        frame(1'b0);
        frame(1'b0);
        chk("R7 one-byte done", {31'd0, done}, 32'd1);

        // R5: early pre-acknowledge is ignored.
        start_msg(2);
        frame(1'b1);
        frame(1'b0);
        chk("R5 early preack ignored", {22'd0, mon_byte, mon_oe, e_n}, {22'd0, ebuf[0], 2'b10});
        frame(1'b0);
        chk("R6 preack accepted later", {22'd0, mon_byte, mon_oe, e_n}, {22'd0, ebuf[1], 2'b11});
        frame(1'b0);
        chk("R6 ack", {31'd0, e_n}, 32'd0);
        frame(1'b0);
        frame(1'b1);
        chk("R7 last preack", {30'd0, mon_oe, e_n}, 32'd1);
        frame(1'b0);
        chk("R7 done after ack", {31'd0, done}, 32'd1);

        // R9: receiver aborts every time; limit counts across retries.
        start_msg(2);
        frame(1'b1);
        frame(1'b1);
        frame(1'b0);
        frame(1'b1);
        chk("R8 first retry", {31'd0, retry}, 32'd1);
        frame(1'b1);
        frame(1'b0);
        frame(1'b1);
        chk("R8 second retry", {30'd0, retry, aborted}, 32'd2);
        frame(1'b1);
        chk("R9 not aborted at 7 across retries", {31'd0, aborted}, 32'd0);
        frame(1'b0);
        chk("R9 aborted at 8 across retries", {29'd0, aborted, mon_oe, e_n}, 32'd5);

        report();
    end
endmodule